// File: doc/BRIEF.md
# Muxed Double-Divider Peripheral Clock Generator

This block produces one peripheral clock from four candidate reference clocks. The reference clocks are slow square waves that the block samples on its core clock. A hardware-driven selector chooses one reference. Two integer divider stages then divide it in cascade, each by a factor of 1 to 6. A glitch-free output gate, controlled by a disable bit, comes last. A small word-addressed register interface holds the divider codes, the gate control and one spare storage register. The select field can be read through this interface but not written. A status output reports the total division that is active, and an error flag reports a divider code that is not legal.

Divider changes never cut an output period short. New codes are taken only when the current output period ends. The gate changes state only while the divided clock is low, so the output never produces a partial pulse.

Top module: `periph_clkgen`

## Requirements
- R1: After reset, the register at byte offset 0xC reads 0x0001_2000 (both divider codes equal 1), offset 0x14 reads 0, `div_total_o` is 1, `div_err_o` is 0, and `clk_out_o` reproduces the high and low times of reference 0.
- R2: `hw_sel_i` values 0, 1, 2 and 3 pick `src_clk_i[0]` to `src_clk_i[3]`. Offset 0x0 returns that value in bits [1:0]. Writes to offset 0x0 have no effect.
- R3: The code for stage A sits in bits [18:16] of offset 0xC, and the code for stage B sits in bits [15:13] of offset 0xC. Codes 1 to 6 divide by that value. `div_total_o` shows the product of the two active factors.
- R4: When the total N is 2 or more, the output stays high for floor(N/2) reference periods and low for N-floor(N/2) reference periods. This gives 50% duty for even N, and a high phase one reference period shorter than the low phase for odd N. When N is 1, the output follows the reference waveform.
- R5: Code 0 or code 7 in either stage is invalid. While such a code is held, `div_err_o` is 1. Once it becomes active, `div_total_o` reads 0 and `clk_out_o` stays low. Writing valid codes restores normal output.
- R6: A new divider setting takes effect only at the start of the next output period. The period in progress completes with the old high and low times, and `div_total_o` keeps the old value until that point.
- R7: Bit 2 of offset 0x14 set to 1 holds the output low, and 0 lets it run. Other bits of 0x14 do not affect the output. Setting or clearing the bit never shortens a high pulse.
- R8: Offset 0x10 is a plain read/write 32-bit register. Offsets 0x18 and 0x1C read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples everything |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk_i | input | 4 | Reference clocks, index = select code |
| hw_sel_i | input | 2 | Hardware source selection |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Byte address for reads and writes |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i` |
| clk_out_o | output | 1 | Gated, divided clock |
| div_total_o | output | 6 | Active total division, 0 when invalid |
| div_err_o | output | 1 | An invalid divider code is programmed |

## Verification
The bench measures high and low run lengths of the output in core cycles and compares them with the times predicted from the reference period and the total N. An odd-factor error would show up as equal phases or as a long high phase. A missing N=1 pass-through would show up as a stuck output. Divider codes are rewritten at the exact cycle an output period begins. A design that applies the change at once gives a first period of the wrong length. The gate is toggled at random points of the divided waveform, and its first pulse after release and its last pulse before stopping must be full length, so a design that gates combinationally shows runt pulses. Codes 0 and 7 in each stage must silence the output rather than wrap a counter, and writes to the select field must leave both the readback and the chosen source unchanged.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
   localparam int FW    = 3;                       // divider code width
   localparam int MAXF  = 6;                       // largest legal factor
   localparam int TW    = $clog2(MAXF * MAXF + 1); // total-division width
   localparam int NSRC  = 4;                       // candidate references
   localparam int SELW  = $clog2(NSRC);
   localparam int NREG  = 6;                       // word slots 0x0 .. 0x14
   localparam int IDX_SEL  = 0;
   localparam int IDX_SPARE = 4;
   localparam int IDX_GATE = 5;

   typedef logic [FW-1:0] fcode_t;

   // Legal codes map to their own value, anything else to zero.
   function automatic fcode_t code_to_factor(input fcode_t c);
      return (c >= fcode_t'(1) && c <= fcode_t'(MAXF)) ? c : '0;
   endfunction
endpackage

// File: rtl/pclk_regs.sv
module pclk_regs
   import pclk_pkg::*;
#(
   parameter int DW        = 32,
   parameter int AW        = 5,
   parameter int DIV_A_IDX = 3,
   parameter int DIV_A_SH  = 16,
   parameter int DIV_B_IDX = 3,
   parameter int DIV_B_SH  = 13,
   parameter int SEL_SH    = 0,
   parameter int GATE_BIT  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [AW-1:0]   addr,
   input  logic [DW-1:0]   wdata,
   input  logic [SELW-1:0] hw_sel,
   output logic [DW-1:0]   rdata,
   output fcode_t          code_a,
   output fcode_t          code_b,
   output logic            gate_dis,
   output logic [SELW-1:0] sel
);
   localparam int WORD_W = AW - 2;

   logic [WORD_W-1:0] word;
   logic [1:0]        unused_byte_lane;
   logic [DW-1:0]     regs_w [1:NREG-1];
   logic [SELW-1:0]   sel_q;

   assign word             = addr[AW-1:2];
   assign unused_byte_lane = addr[1:0];

   // Select field mirrors the hardware value; bus writes never reach it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= '0;
      else        sel_q <= hw_sel;
   end

   for (genvar i = 1; i < NREG; i++) begin : g_reg
      localparam logic [DW-1:0] RV_A = (i == DIV_A_IDX) ? (DW'(1) << DIV_A_SH) : '0;
      localparam logic [DW-1:0] RV_B = (i == DIV_B_IDX) ? (DW'(1) << DIV_B_SH) : '0;
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             q <= RV_A | RV_B;
         else if (wr_en && word == WORD_W'(i))   q <= wdata;
      end
      assign regs_w[i] = q;
   end

   always_comb begin
      rdata = '0;
      if (word == WORD_W'(IDX_SEL)) rdata[SEL_SH +: SELW] = sel_q;
      for (int i = 1; i < NREG; i++)
         if (word == WORD_W'(i)) rdata = regs_w[i];
   end

   assign code_a   = regs_w[DIV_A_IDX][DIV_A_SH +: FW];
   assign code_b   = regs_w[DIV_B_IDX][DIV_B_SH +: FW];
   assign gate_dis = regs_w[IDX_GATE][GATE_BIT];
   assign sel      = sel_q;
endmodule

// File: rtl/pclk_divchain.sv
module pclk_divchain
   import pclk_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rise,     // one-cycle event per reference period
   input  logic          src_lvl,  // sampled reference level (N = 1 path)
   input  fcode_t        code_a,
   input  fcode_t        code_b,
   output logic          div_lvl,
   output logic [TW-1:0] total,
   output logic          load
);
   fcode_t fa_q, fb_q, ca_q, cb_q;
   logic   act_ok, a_last, b_last;
   logic [TW-1:0] pos, half;

   assign act_ok = (fa_q != '0) && (fb_q != '0);
   assign a_last = (ca_q == FW'(fa_q - FW'(1)));
   assign b_last = (cb_q == FW'(fb_q - FW'(1)));
   assign load   = !act_ok || (rise && a_last && b_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fa_q <= FW'(1);
         fb_q <= FW'(1);
         ca_q <= '0;
         cb_q <= '0;
      end else if (load) begin
         fa_q <= code_to_factor(code_a);
         fb_q <= code_to_factor(code_b);
         ca_q <= '0;
         cb_q <= '0;
      end else if (rise) begin
         if (a_last) begin
            ca_q <= '0;
            cb_q <= FW'(cb_q + FW'(1));
         end else begin
            ca_q <= FW'(ca_q + FW'(1));
         end
      end
   end

   assign total = act_ok ? TW'(TW'(fa_q) * TW'(fb_q)) : '0;
   assign pos   = TW'(TW'(cb_q) * TW'(fa_q)) + TW'(ca_q);
   assign half  = total >> 1;

   always_comb begin
      if (!act_ok)              div_lvl = 1'b0;
      else if (total == TW'(1)) div_lvl = src_lvl;
      else                      div_lvl = (pos < half);
   end
endmodule

// File: rtl/pclk_gate.sv
module pclk_gate #(
   parameter bit SYNC = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic div_lvl,
   input  logic dis,
   output logic en_o,
   output logic clk_o
);
   logic en_q, out_q;

   if (SYNC) begin : g_sync
      // Enable only moves while the divided clock is low: whole pulses only.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       en_q <= 1'b1;
         else if (!div_lvl) en_q <= !dis;
      end
   end else begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) en_q <= 1'b1;
         else        en_q <= !dis;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= 1'b0;
      else        out_q <= div_lvl & en_q;
   end

   assign en_o  = en_q;
   assign clk_o = out_q;
endmodule

// File: rtl/periph_clkgen.sv
module periph_clkgen
   import pclk_pkg::*;
#(
   parameter int DW        = 32,
   parameter int AW        = 5,
   parameter int DIV_A_IDX = 3,
   parameter int DIV_A_SH  = 16,
   parameter int DIV_B_IDX = 3,
   parameter int DIV_B_SH  = 13,
   parameter int SEL_SH    = 0,
   parameter int GATE_BIT  = 2,
   parameter bit SYNC_GATE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_clk_i,
   input  logic [SELW-1:0] hw_sel_i,
   input  logic            wr_en_i,
   input  logic [AW-1:0]   addr_i,
   input  logic [DW-1:0]   wr_data_i,
   output logic [DW-1:0]   rd_data_o,
   output logic            clk_out_o,
   output logic [TW-1:0]   div_total_o,
   output logic            div_err_o
);
   if (AW < 5) begin : g_bad_aw
      $error("address too narrow for six word slots");
   end
   if (DIV_A_IDX < 1 || DIV_A_IDX > 3 || DIV_B_IDX < 1 || DIV_B_IDX > 3) begin : g_bad_idx
      $error("divider fields must live in word slots 1 to 3");
   end
   if (DIV_A_SH > DW - FW || DIV_B_SH > DW - FW || SEL_SH > DW - SELW || GATE_BIT >= DW) begin : g_bad_sh
      $error("field position outside the data word");
   end
   if (DIV_A_IDX == DIV_B_IDX &&
       ((DIV_A_SH > DIV_B_SH) ? (DIV_A_SH - DIV_B_SH) : (DIV_B_SH - DIV_A_SH)) < FW) begin : g_overlap
      $error("divider fields overlap");
   end

   fcode_t          code_a, code_b;
   logic            gate_dis, src_sel, src_q, src_rise, div_lvl, chain_load, gate_en;
   logic [SELW-1:0] sel;

   pclk_regs #(
      .DW(DW), .AW(AW), .DIV_A_IDX(DIV_A_IDX), .DIV_A_SH(DIV_A_SH),
      .DIV_B_IDX(DIV_B_IDX), .DIV_B_SH(DIV_B_SH), .SEL_SH(SEL_SH), .GATE_BIT(GATE_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .addr(addr_i), .wdata(wr_data_i),
      .hw_sel(hw_sel_i), .rdata(rd_data_o), .code_a(code_a), .code_b(code_b),
      .gate_dis(gate_dis), .sel(sel)
   );

   assign src_sel = src_clk_i[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q <= 1'b0;
      else        src_q <= src_sel;
   end
   assign src_rise = src_sel & ~src_q;

   pclk_divchain u_chain (
      .clk(clk), .rst_n(rst_n), .rise(src_rise), .src_lvl(src_q),
      .code_a(code_a), .code_b(code_b), .div_lvl(div_lvl),
      .total(div_total_o), .load(chain_load)
   );

   pclk_gate #(.SYNC(SYNC_GATE)) u_gate (
      .clk(clk), .rst_n(rst_n), .div_lvl(div_lvl), .dis(gate_dis),
      .en_o(gate_en), .clk_o(clk_out_o)
   );

   assign div_err_o = (code_to_factor(code_a) == '0) || (code_to_factor(code_b) == '0);
endmodule

// File: rtl/pclk_chk.sv
module pclk_chk
   import pclk_pkg::*;
#(
   parameter bit SYNC = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          clk_out,
   input logic [TW-1:0] total,
   input logic          load,
   input logic          gate_en,
   input logic          div_lvl
);
   // R3: reported total never exceeds the largest legal product
   p_total_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      total <= TW'(MAXF * MAXF));

   // R5: an inactive chain keeps the output low
   p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (total == '0) |=> !clk_out);

   // R6: the active total only moves right after a period-boundary load
   p_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(total) |-> $past(load));

   if (SYNC) begin : g_sync_chk
      // R7: gate enable only changes during the low phase
      p_gate_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(gate_en) |-> !$past(div_lvl));
   end
endmodule

bind periph_clkgen pclk_chk #(.SYNC(SYNC_GATE)) u_chk (
   .clk(clk), .rst_n(rst_n), .clk_out(clk_out_o), .total(div_total_o),
   .load(chain_load), .gate_en(gate_en), .div_lvl(div_lvl)
);

// File: tb/tb_periph_clkgen.sv
module tb_periph_clkgen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  src = '0;
   logic [1:0]  hw_sel = '0;
   logic        wr_en = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        clk_out;
   logic [5:0]  total;
   logic        err;
   int nvec = 0;
   int nfail = 0;
   int sp [4] = '{4, 6, 8, 10};  // reference periods in core cycles

   always #2 clk = ~clk;

   periph_clkgen dut (
      .clk(clk), .rst_n(rst_n), .src_clk_i(src), .hw_sel_i(hw_sel),
      .wr_en_i(wr_en), .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata),
      .clk_out_o(clk_out), .div_total_o(total), .div_err_o(err)
   );

   initial begin : srcgen
      int cnt [4];
      cnt = '{default: 0};
      forever begin
         @(negedge clk);
         for (int k = 0; k < 4; k++) begin
            cnt[k] = (cnt[k] + 1) % sp[k];
            src[k] = (cnt[k] < sp[k] / 2);
         end
      end
   end

   task automatic chk(input string req, input longint act, input longint exp);
      nvec++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   function automatic logic [31:0] div_word(input int fa, input int fb);
      return (32'(fa) << 16) | (32'(fb) << 13);
   endfunction

   function automatic int exp_hi(input int n, input int p);
      return (n == 1) ? p / 2 : (n / 2) * p;
   endfunction

   function automatic int exp_lo(input int n, input int p);
      return (n == 1) ? p - p / 2 : (n - n / 2) * p;
   endfunction

   task automatic settle();
      repeat (800) @(negedge clk);
   endtask

   task automatic measure(input bit from_now, output int hi, output int lo);
      int t;
      hi = 0; lo = 0; t = 0;
      if (!from_now) while (clk_out && t < 3000) begin @(negedge clk); t++; end
      while (!clk_out && t < 3000) begin @(negedge clk); t++; end
      while (clk_out && t < 3000) begin @(negedge clk); hi++; t++; end
      while (!clk_out && t < 3000) begin @(negedge clk); lo++; t++; end
   endtask

   task automatic count_high(input int n, output int c);
      c = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (clk_out) c++;
      end
   endtask

   task automatic wait_rise();
      while (clk_out) @(negedge clk);
      while (!clk_out) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      nvec++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin : main
      logic [31:0] d;
      int hi, lo, c;
      void'($urandom(32'h5eed_0a17));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd(5'h0C, d);  chk("R1 div reg", d, 32'h0001_2000);
      rd(5'h14, d);  chk("R1 gate reg", d, 0);
      chk("R1 total", total, 1);
      chk("R1 err", err, 0);
      measure(0, hi, lo);
      chk("R1 hi", hi, 2);
      chk("R1 lo", lo, 2);

      // R2: select is hardware-driven, bus writes ignored
      wr(5'h00, 32'hFFFF_FFFF);
      rd(5'h00, d);  chk("R2 sel ro", d, 0);
      measure(0, hi, lo);
      chk("R2 src0 after write hi", hi, 2);
      hw_sel = 2'd2;
      repeat (4) @(negedge clk);
      rd(5'h00, d);  chk("R2 sel read", d, 2);
      settle();
      measure(0, hi, lo);
      chk("R2 src2 hi", hi, 4);
      chk("R2 src2 lo", lo, 4);

      // R4/R3: directed odd and even factors on reference 0 (period 4)
      hw_sel = 2'd0;
      wr(5'h0C, div_word(3, 1)); settle(); measure(0, hi, lo);
      chk("R4 N3 hi", hi, 4);  chk("R4 N3 lo", lo, 8);  chk("R3 N3 total", total, 3);
      wr(5'h0C, div_word(5, 1)); settle(); measure(0, hi, lo);
      chk("R4 N5 hi", hi, 8);  chk("R4 N5 lo", lo, 12);
      wr(5'h0C, div_word(1, 6)); settle(); measure(0, hi, lo);
      chk("R3 stageB hi", hi, 12); chk("R3 stageB lo", lo, 12); chk("R3 stageB total", total, 6);

      // R5: invalid codes in either stage
      wr(5'h0C, div_word(7, 1));
      chk("R5 err code7", err, 1);
      repeat (400) @(negedge clk);
      chk("R5 total zero", total, 0);
      count_high(200, c); chk("R5 quiet", c, 0);
      wr(5'h0C, div_word(3, 0));
      chk("R5 err code0", err, 1);
      repeat (100) @(negedge clk);
      count_high(200, c); chk("R5 quiet stageB", c, 0);
      wr(5'h0C, div_word(2, 2));
      chk("R5 err clear", err, 0);
      settle(); measure(0, hi, lo);
      chk("R5 recover hi", hi, 8); chk("R5 recover total", total, 4);

      // R6: change lands at the next period start
      hw_sel = 2'd1;
      settle();
      wait_rise();
      addr = 5'h0C; wdata = div_word(3, 2); wr_en = 1'b1;
      hi = 0; lo = 0;
      do begin @(negedge clk); wr_en = 1'b0; hi++; end while (clk_out);
      chk("R6 old total kept", total, 4);
      do begin @(negedge clk); lo++; end while (!clk_out);
      chk("R6 old hi", hi, 12);
      chk("R6 old lo", lo, 12);
      measure(1, hi, lo);
      chk("R6 new hi", hi, 18);
      chk("R6 new lo", lo, 18);
      chk("R6 new total", total, 6);

      // R7: gate, whole pulses only (N=6 on reference 0)
      hw_sel = 2'd0;
      wr(5'h0C, div_word(6, 1)); settle();
      wr(5'h14, ~32'h4); settle(); measure(0, hi, lo);
      chk("R7 other bits hi", hi, 12); chk("R7 other bits lo", lo, 12);
      wait_rise();
      addr = 5'h14; wdata = 32'h4; wr_en = 1'b1;
      hi = 0;
      do begin @(negedge clk); wr_en = 1'b0; hi++; end while (clk_out);
      chk("R7 last pulse full", hi, 12);
      count_high(100, c); chk("R7 stopped", c, 0);
      for (int t = 0; t < 4; t++) begin
         repeat (($urandom % 24) + 1) @(negedge clk);
         wr(5'h14, 32'h0);
         measure(1, hi, lo);
         chk("R7 first pulse hi", hi, 12);
         chk("R7 first pulse lo", lo, 12);
         wr(5'h14, 32'h4);
         repeat (60) @(negedge clk);
      end
      wr(5'h14, 32'h0);

      // R8: spare register and empty slots
      wr(5'h10, 32'hA5A5_1234);
      rd(5'h10, d); chk("R8 spare", d, 32'hA5A5_1234);
      wr(5'h18, 32'hFFFF_FFFF);
      rd(5'h18, d); chk("R8 empty 0x18", d, 0);
      rd(5'h1C, d); chk("R8 empty 0x1C", d, 0);

      // R3/R4: random settings
      for (int it = 0; it < 16; it++) begin
         int s, fa, fb, n;
         s  = $urandom % 4;
         fa = 1 + ($urandom % 6);
         fb = 1 + ($urandom % 6);
         n  = fa * fb;
         hw_sel = 2'(s);
         wr(5'h0C, div_word(fa, fb));
         settle();
         measure(0, hi, lo);
         chk("R4 random hi", hi, exp_hi(n, sp[s]));
         chk("R4 random lo", lo, exp_lo(n, sp[s]));
         chk("R3 random total", total, n);
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule